// File: doc/BRIEF.md
# Reuse-Counter Global Victim Selector

This block chooses which data block to evict when a cache that decouples tags from data needs a free block and none is left. Every data block in the store has a small saturating reuse counter. Hits raise the counter of the block they touch. A single sweep pointer walks the whole store. A victim search starts at the pointer and looks at one counter per cycle. A counter at zero names the victim. A non-zero counter is lowered by one and the pointer moves on to the next block. If the search runs long, it is cut off at a fixed number of probes.

The surrounding cache controller raises `vict_req` for one cycle and waits for `vict_done`. It then installs the new line in block `vict_idx` and reports the install on the fill port. The fill clears that block's counter and moves the pointer just past it, so a freshly loaded line is the last one the next sweep looks at. Tag lookup and the data array belong to other blocks.

Top module: `reuse_victim_sel`

## Requirements
- R1: `vict_done` is high for exactly one cycle per accepted request, only in the cycle the victim is chosen, and `vict_idx` names the victim in that same cycle.
- R2: After reset every counter is 0, the pointer names block 0 and no search is running. A first request therefore returns block 0 one cycle after it is accepted.
- R3: A hit on a block adds one to its 2-bit counter, and the counter stays at 3 once it has reached 3.
- R4: A request made while idle starts a search on the next cycle at the block the pointer names. A probed counter equal to 0 makes that block the victim, and the pointer stays on it.
- R5: A probed counter that is not zero, and is not the last allowed probe, is lowered by exactly one. The pointer then moves up by one, so each search cycle examines one new block.
- R6: The search takes the block at its 6th probe (parameter MAX_PROBES) as the victim, whatever its counter value.
- R7: The pointer wraps from the highest block index back to block 0, both while sweeping and after a fill of the last block.
- R8: A fill clears the filled block's counter, and this takes priority over a hit to the same block in the same cycle. While idle, a fill also moves the pointer to the block after the filled one. While a search runs, the pointer is left to the search.
- R9: When a hit lands on the block being probed and lowered in the same cycle, the decrement is applied first and the saturating increment after it.
- R10: A request that arrives while a search runs, including in the cycle `vict_done` is high, is ignored and starts no further search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | A hit occurred on block `hit_idx` |
| hit_idx | input | IDX_W | Block index of the hit |
| fill_vld | input | 1 | Block `fill_idx` was just loaded |
| fill_idx | input | IDX_W | Block index of the fill |
| vict_req | input | 1 | Start a victim search (single-cycle pulse) |
| vict_done | output | 1 | Victim chosen this cycle |
| vict_idx | output | IDX_W | Victim block index, valid with `vict_done` |

## Verification
The bench builds the selector with 8 blocks and the default cap of 6 probes. With 6 probes out of 8 blocks, a capped search is reached by saturating every counter with a few hits. A sweep that starts near the top of the index range crosses the wrap from block 7 to block 0 inside a single search. The small store also makes random hits, fills and requests collide often on the probed block, so a behavioural reference model can compare the outputs on every cycle and catch those collisions.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  localparam int unsigned CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_TOP = '1;

  typedef logic [CTR_W-1:0] ctr_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_st_e;

  // Saturating increment used by hits.
  function automatic ctr_t ctr_bump(ctr_t v);
    return (v == CTR_TOP) ? v : ctr_t'(v + 1'b1);
  endfunction

  // Floor-at-zero decrement used by the sweep.
  function automatic ctr_t ctr_drain(ctr_t v);
    return (v == '0) ? v : ctr_t'(v - 1'b1);
  endfunction

  // Combined update: clear wins, then drain, then bump.
  function automatic ctr_t ctr_next(ctr_t v, logic clr, logic drain, logic bump);
    ctr_t t;
    if (clr) begin
      t = '0;
    end else begin
      t = drain ? ctr_drain(v) : v;
      t = bump ? ctr_bump(t) : t;
    end
    return t;
  endfunction

  // Circular successor of an index in a store of n blocks.
  function automatic int unsigned idx_step(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rvs_ctr_table.sv
module rvs_ctr_table
  import rvs_pkg::*;
#(
  parameter int unsigned N_BLOCKS = 64,
  parameter int unsigned IDX_W    = $clog2(N_BLOCKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hit_vld,
  input  logic [IDX_W-1:0]          hit_idx,
  input  logic                      fill_vld,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic                      drain_vld,
  input  logic [IDX_W-1:0]          drain_idx,
  input  logic [IDX_W-1:0]          rd_idx,
  output ctr_t                      rd_val,
  output logic [N_BLOCKS*CTR_W-1:0] ctr_flat
);

  ctr_t ctr_arr [N_BLOCKS];

  for (genvar g = 0; g < N_BLOCKS; g++) begin : g_entry
    logic hit_here;
    logic fill_here;
    logic drain_here;
    ctr_t ctr_q;

    assign hit_here   = hit_vld   && (hit_idx   == IDX_W'(g));
    assign fill_here  = fill_vld  && (fill_idx  == IDX_W'(g));
    assign drain_here = drain_vld && (drain_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q <= '0;
      end else begin
        ctr_q <= ctr_next(ctr_q, fill_here, drain_here, hit_here);
      end
    end

    assign ctr_arr[g]                   = ctr_q;
    assign ctr_flat[g*CTR_W +: CTR_W]   = ctr_q;
  end

  assign rd_val = ctr_arr[rd_idx];

endmodule

// File: rtl/rvs_sweep_ptr.sv
module rvs_sweep_ptr
  import rvs_pkg::*;
#(
  parameter int unsigned N_BLOCKS = 64,
  parameter int unsigned IDX_W    = $clog2(N_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             owned,
  input  logic             advance,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] ptr_q
);

  logic [IDX_W-1:0] ptr_succ;
  logic [IDX_W-1:0] fill_succ;
  logic [IDX_W-1:0] ptr_d;

  assign ptr_succ  = IDX_W'(idx_step(32'(ptr_q), N_BLOCKS));
  assign fill_succ = IDX_W'(idx_step(32'(fill_idx), N_BLOCKS));

  always_comb begin
    ptr_d = ptr_q;
    if (owned) begin
      if (advance) ptr_d = ptr_succ;
    end else if (fill_vld) begin
      ptr_d = fill_succ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/rvs_search_fsm.sv
module rvs_search_fsm
  import rvs_pkg::*;
#(
  parameter int unsigned MAX_PROBES = 6,
  parameter int unsigned PW         = $clog2(MAX_PROBES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  ctr_t          probe_val,
  output logic          search_active,
  output logic [PW-1:0] probe_num,
  output logic          pick,
  output logic          advance
);

  localparam logic [PW-1:0] LAST_PROBE = PW'(MAX_PROBES - 1);

  sweep_st_e     st_q, st_d;
  logic [PW-1:0] num_d;
  logic          at_cap;
  logic          zero_hit;

  assign search_active = (st_q == ST_SWEEP);
  assign at_cap        = (probe_num == LAST_PROBE);
  assign zero_hit      = (probe_val == '0);
  assign pick          = search_active && (zero_hit || at_cap);
  assign advance       = search_active && !pick;

  always_comb begin
    st_d  = st_q;
    num_d = probe_num;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d  = ST_SWEEP;
          num_d = '0;
        end
      end
      ST_SWEEP: begin
        if (pick) begin
          st_d  = ST_IDLE;
          num_d = '0;
        end else begin
          num_d = probe_num + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      probe_num <= '0;
    end else begin
      st_q      <= st_d;
      probe_num <= num_d;
    end
  end

endmodule

// File: rtl/reuse_victim_sel.sv
module reuse_victim_sel
  import rvs_pkg::*;
#(
  parameter int unsigned N_BLOCKS   = 64,
  parameter int unsigned MAX_PROBES = 6,
  parameter int unsigned IDX_W      = $clog2(N_BLOCKS),
  parameter int unsigned PW         = $clog2(MAX_PROBES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             vict_req,
  output logic             vict_done,
  output logic [IDX_W-1:0] vict_idx
);

  // Internal events, named for the checker.
  logic                      search_active;
  logic [PW-1:0]             probe_num;
  ctr_t                      probe_val;
  logic                      pick;
  logic                      advance;
  logic [IDX_W-1:0]          ptr_q;
  logic [N_BLOCKS*CTR_W-1:0] ctr_flat;

  rvs_ctr_table #(
    .N_BLOCKS (N_BLOCKS),
    .IDX_W    (IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vld   (hit_vld),
    .hit_idx   (hit_idx),
    .fill_vld  (fill_vld),
    .fill_idx  (fill_idx),
    .drain_vld (advance),
    .drain_idx (ptr_q),
    .rd_idx    (ptr_q),
    .rd_val    (probe_val),
    .ctr_flat  (ctr_flat)
  );

  rvs_sweep_ptr #(
    .N_BLOCKS (N_BLOCKS),
    .IDX_W    (IDX_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .owned    (search_active),
    .advance  (advance),
    .fill_vld (fill_vld),
    .fill_idx (fill_idx),
    .ptr_q    (ptr_q)
  );

  rvs_search_fsm #(
    .MAX_PROBES (MAX_PROBES),
    .PW         (PW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (vict_req),
    .probe_val     (probe_val),
    .search_active (search_active),
    .probe_num     (probe_num),
    .pick          (pick),
    .advance       (advance)
  );

  assign vict_done = pick;
  assign vict_idx  = ptr_q;

endmodule

// File: rtl/rvs_checks.sv
module rvs_checks
  import rvs_pkg::*;
#(
  parameter int unsigned N_BLOCKS   = 64,
  parameter int unsigned MAX_PROBES = 6,
  parameter int unsigned IDX_W      = $clog2(N_BLOCKS),
  parameter int unsigned PW         = $clog2(MAX_PROBES + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      hit_vld,
  input logic [IDX_W-1:0]          hit_idx,
  input logic                      fill_vld,
  input logic [IDX_W-1:0]          fill_idx,
  input logic                      vict_req,
  input logic                      vict_done,
  input logic [IDX_W-1:0]          vict_idx,
  input logic                      search_active,
  input logic [PW-1:0]             probe_num,
  input ctr_t                      probe_val,
  input logic [IDX_W-1:0]          ptr_q,
  input logic [N_BLOCKS*CTR_W-1:0] ctr_flat
);

  ctr_t ctr_view [N_BLOCKS];
  for (genvar g = 0; g < N_BLOCKS; g++) begin : g_view
    assign ctr_view[g] = ctr_flat[g*CTR_W +: CTR_W];
  end

  logic probe_touched;
  assign probe_touched = (hit_vld && hit_idx == ptr_q) || (fill_vld && fill_idx == ptr_q);

  // R1: done is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vict_done |=> !vict_done);

  // R1: done only while a search runs
  a_r1_done_in_search: assert property (@(posedge clk) disable iff (!rst_n)
    vict_done |-> search_active);

  // R4: a pick happens on a zero counter or at the cap
  a_r4_pick_reason: assert property (@(posedge clk) disable iff (!rst_n)
    vict_done |-> (probe_val == '0 || probe_num == PW'(MAX_PROBES - 1)));

  // R4: the pointer stays on the victim
  a_r4_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    vict_done |=> ptr_q == $past(vict_idx));

  // R5: non-final probe moves the pointer by one
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (search_active && !vict_done) |=>
      ptr_q == IDX_W'(idx_step(32'($past(ptr_q)), N_BLOCKS)));

  // R5: an untouched probed counter drops by exactly one
  a_r5_drain_one: assert property (@(posedge clk) disable iff (!rst_n)
    (search_active && !vict_done && !probe_touched) |=>
      ctr_view[$past(ptr_q)] == ctr_t'($past(probe_val) - 1'b1));

  // R6: the probe count never passes the cap
  a_r6_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    search_active |-> probe_num < PW'(MAX_PROBES));

  // R8: a fill leaves the block's counter at zero
  a_r8_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> ctr_view[$past(fill_idx)] == '0);

  // R10: a request during a search does not end it early
  a_r10_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (search_active && vict_req && !vict_done) |=> search_active);

endmodule

bind reuse_victim_sel rvs_checks #(
  .N_BLOCKS   (N_BLOCKS),
  .MAX_PROBES (MAX_PROBES),
  .IDX_W      (IDX_W),
  .PW         (PW)
) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .hit_vld       (hit_vld),
  .hit_idx       (hit_idx),
  .fill_vld      (fill_vld),
  .fill_idx      (fill_idx),
  .vict_req      (vict_req),
  .vict_done     (vict_done),
  .vict_idx      (vict_idx),
  .search_active (search_active),
  .probe_num     (probe_num),
  .probe_val     (probe_val),
  .ptr_q         (ptr_q),
  .ctr_flat      (ctr_flat)
);

// File: tb/reuse_victim_sel_tb.sv
`timescale 1ns/1ps
module reuse_victim_sel_tb;

  localparam int NB  = 8;
  localparam int CAP = 6;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hit_vld = 1'b0;
  logic [IW-1:0] hit_idx = '0;
  logic          fill_vld = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic          vict_req = 1'b0;
  logic          vict_done;
  logic [IW-1:0] vict_idx;

  always #4 clk = ~clk;

  reuse_victim_sel #(.N_BLOCKS(NB), .MAX_PROBES(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hit_vld(hit_vld), .hit_idx(hit_idx),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .vict_req(vict_req), .vict_done(vict_done), .vict_idx(vict_idx)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit ended  = 0;

  // Behavioural reference state.
  int m_ctr [NB];
  int m_ptr   = 0;
  bit m_busy  = 0;
  int m_probe = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One cycle: compare outputs, drive inputs, advance the model.
  task automatic step(input bit hv, input int hi, input bit fv, input int fi,
                      input bit rq, input string tag,
                      output bit got_done, output int got_idx);
    bit exp_done;
    @(negedge clk);
    exp_done = m_busy && (m_ctr[m_ptr] == 0 || m_probe == CAP - 1);
    got_done = vict_done;
    got_idx  = int'(vict_idx);
    check(vict_done == exp_done, tag, int'(vict_done), int'(exp_done));
    if (exp_done) check(int'(vict_idx) == m_ptr, tag, int'(vict_idx), m_ptr);
    hit_vld  = hv; hit_idx  = IW'(hi);
    fill_vld = fv; fill_idx = IW'(fi);
    vict_req = rq;
    for (int i = 0; i < NB; i++) begin
      if (fv && fi == i) m_ctr[i] = 0;
      else begin
        if (m_busy && !exp_done && m_ptr == i && m_ctr[i] > 0) m_ctr[i]--;
        if (hv && hi == i && m_ctr[i] < 3) m_ctr[i]++;
      end
    end
    if (m_busy) begin
      if (exp_done) m_busy = 0;
      else begin m_ptr = (m_ptr + 1) % NB; m_probe++; end
    end else begin
      if (fv) m_ptr = (fi + 1) % NB;
      if (rq) begin m_busy = 1; m_probe = 0; end
    end
  endtask

  task automatic idle(input int n, input string tag);
    bit d; int x;
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, tag, d, x);
  endtask

  task automatic hit(input int b, input int times, input string tag);
    bit d; int x;
    for (int k = 0; k < times; k++) step(1, b, 0, 0, 0, tag, d, x);
  endtask

  task automatic fill(input int b, input string tag);
    bit d; int x;
    step(0, 0, 1, b, 0, tag, d, x);
  endtask

  // Issue a request and return victim and cycles from acceptance to done.
  task automatic request(input string tag, output int victim, output int lat);
    bit d; int x;
    step(0, 0, 0, 0, 1, tag, d, x);
    lat = 0; victim = -1;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 0, 0, 0, tag, d, x);
      lat++;
      if (d) begin victim = x; break; end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !ended) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int v, l, dones;
    bit d; int x;
    for (int i = 0; i < NB; i++) m_ctr[i] = 0;
    repeat (3) @(negedge clk);
    check(vict_done == 1'b0, "R2 reset done low", int'(vict_done), 0);
    rst_n = 1'b1;
    idle(2, "R2");

    // R2: fresh reset picks block 0 after one cycle.
    request("R2", v, l);
    check(v == 0, "R2 first victim", v, 0);
    check(l == 1, "R2 first latency", l, 1);

    // R8: fill moves pointer past the filled block.
    fill(0, "R8");
    request("R8", v, l);
    check(v == 1, "R8 pointer after fill", v, 1);

    // R5: decrement by one per probe.
    hit(1, 2, "R3"); hit(2, 1, "R3");
    fill(0, "R8");
    request("R5", v, l);
    check(v == 3 && l == 3, "R5 sweep victim", v, 3);
    fill(0, "R8");
    request("R5", v, l);
    check(v == 2 && l == 2, "R5 drained by one", v, 2);

    // R3: counter saturates at 3.
    hit(4, 5, "R3");
    for (int k = 0; k < 3; k++) begin
      fill(3, "R8");
      request("R3", v, l);
      check(v == 5, "R3 saturated block survives", v, 5);
    end
    fill(3, "R8");
    request("R3", v, l);
    check(v == 4 && l == 1, "R3 saturation at 3", v, 4);

    // R6: all counters at 3, cap at the 6th probe.
    for (int b = 0; b < NB; b++) hit(b, 3, "R3");
    fill(7, "R8");
    request("R6", v, l);
    check(v == 5, "R6 capped victim", v, 5);
    check(l == CAP, "R6 capped latency", l, CAP);

    // R7: sweep wraps from block 7 to block 0.
    hit(7, 3, "R3");
    fill(5, "R7");
    request("R7", v, l);
    check(v == 3 && l == CAP, "R7 wrap victim", v, 3);

    // R9: hit on the probed block in the same cycle.
    fill(7, "R8");
    step(0, 0, 0, 0, 1, "R9", d, x);
    step(1, 0, 0, 0, 0, "R9", d, x);
    v = -1;
    for (int k = 0; k < 20 && v < 0; k++) begin
      step(0, 0, 0, 0, 0, "R9", d, x);
      if (d) v = x;
    end
    check(v == 5, "R9 search victim", v, 5);
    fill(7, "R8");
    request("R9", v, l);
    check(v == 1 && l == 2, "R9 decrement then increment", v, 1);

    // R10: requests during a search are ignored.
    for (int b = 0; b < NB; b++) hit(b, 3, "R3");
    fill(7, "R8");
    step(0, 0, 0, 0, 1, "R10", d, x);
    dones = 0;
    for (int k = 0; k < 20; k++) begin
      step(0, 0, 0, 0, (k < 6), "R10", d, x);
      if (d) dones++;
    end
    check(dones == 1, "R10 one done only", dones, 1);

    // R8: fill beats hit on the same block.
    step(1, 2, 1, 2, 0, "R8", d, x);
    fill(1, "R8");
    request("R8", v, l);
    check(v == 2 && l == 1, "R8 fill over hit", v, 2);

    // R1: random traffic against the model on every cycle.
    for (int k = 0; k < 3000; k++) begin
      step(($urandom_range(2) == 0), $urandom_range(NB - 1),
           ($urandom_range(5) == 0), $urandom_range(NB - 1),
           ($urandom_range(3) == 0), "R1", d, x);
    end
    idle(10, "R1");
    finish_run();
  end

endmodule